// File: doc/BRIEF.md
# Partition RESET Vector Generator

This block prepares the write operations for one memory line stored in cross-point resistive arrays, with each array taking an 8-bit slice of the line. From the old and new contents it keeps only the bits that change. A bit that falls from 1 to 0 needs a RESET. A bit that rises from 0 to 1 needs a SET. On top of those true operations it adds padding RESETs inside each 8-bit slice. These spread the word-line current over several points along the line, which breaks the array into smaller equivalent circuits. Every padding RESET is followed later by a SET on the same bit.

A start pulse captures the line and the two phase durations. The block then presents the RESET vector for a programmable number of cycles. After that it presents the SET vector for a programmable number of cycles. At the end it raises a one-cycle done pulse. All slices are computed in parallel in a single combinational stage.

Top module: `prv_partition_reset`

## Requirements
- R1: Only changed bits are written. A bit with old=1 and new=0 is a true RESET, a bit with old=0 and new=1 is a true SET, and a bit with old equal to new appears in neither vector unless padding selects it.
- R2: Bits 8g to 8g+7 of the line form slice g. A slice whose true RESETs all lie in its local bits 0 to 2 gets no padding.
- R3: In any other slice, the local bits are viewed as pairs {0,1}, {2,3}, {4,5} and {6,7}. Call H the pair that holds the highest local true RESET. Every pair below H that holds no true RESET gets a padding RESET on its upper (odd) bit. For example, a single RESET on local bit 7 adds RESETs on bits 5, 3 and 1.
- R4: Every padding bit is also present in the SET vector. A padding bit that already carries a true SET keeps that single SET.
- R5: Each slice's vectors depend only on that slice's old and new bits, and all slices are produced in the same cycle.
- R6: When phase is idle and start is sampled high, the next cycle begins the RESET phase (phase=1). That phase lasts max(rst_cycles,1) cycles, during which reset_vec shows the RESET vector and set_vec is zero.
- R7: The SET phase (phase=2) follows the last RESET cycle at once. It lasts max(set_cycles,1) cycles, during which set_vec shows the SET vector and reset_vec is zero.
- R8: The cycle after the last SET cycle, done is high for exactly one cycle and phase returns to idle (0). In idle both vectors are zero.
- R9: A start pulse that arrives while phase is not idle is ignored.
- R10: The data and both durations are captured when start is accepted. Changes on those inputs during a run have no effect on it.
- R11: After reset, phase is idle, done is low and both vectors are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a write when idle |
| old_data | input | LINE_W | Current line contents |
| new_data | input | LINE_W | Line contents to be written |
| rst_cycles | input | CNT_W | RESET phase length in cycles |
| set_cycles | input | CNT_W | SET phase length in cycles |
| reset_vec | output | LINE_W | Bits to RESET, valid in phase 1 |
| set_vec | output | LINE_W | Bits to SET, valid in phase 2 |
| phase | output | 2 | 0 idle, 1 RESET, 2 SET |
| done | output | 1 | One-cycle pulse after the SET phase |

## Verification
An error in the padding logic shows up on reset_vec in the very first cycle of the RESET phase. The same error shows up again on set_vec in the first SET cycle, so the bench compares full vectors at both points. A phase counter that is wrong makes a phase shorter or longer than programmed, and that is seen within one cycle of the expected transition. A capture register that is not held, or a start that is taken while busy, changes the vectors during a phase or starts a second run after done, and the checks right after done expose it.

// File: rtl/prv_pkg.sv
package prv_pkg;

    localparam int GRP_W = 8;
    localparam int PAIRS = GRP_W / 2;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_RESET = 2'd1,
        PH_SET   = 2'd2
    } phase_e;

    typedef struct packed {
        logic [GRP_W-1:0] rst_ops;
        logic [GRP_W-1:0] set_ops;
    } grp_ops_t;

    // Padding mask for one slice: empty pairs below the highest RESET pair
    // receive a RESET on their odd bit. Slices with RESETs only in bits 0..2
    // are left as they are.
    function automatic logic [GRP_W-1:0] pad_mask(input logic [GRP_W-1:0] true_rst);
        logic [GRP_W-1:0] add;
        logic             seen;
        add  = '0;
        seen = 1'b0;
        if (|true_rst[GRP_W-1:3]) begin
            for (int p = PAIRS - 1; p >= 0; p--) begin
                if (seen && (true_rst[2*p +: 2] == 2'b00))
                    add[2*p+1] = 1'b1;
                if (|true_rst[2*p +: 2])
                    seen = 1'b1;
            end
        end
        return add;
    endfunction

endpackage

// File: rtl/prv_group_part.sv
module prv_group_part
    import prv_pkg::*;
(
    input  logic [GRP_W-1:0] old_grp,
    input  logic [GRP_W-1:0] new_grp,
    output grp_ops_t         ops
);
    logic [GRP_W-1:0] true_rst;
    logic [GRP_W-1:0] true_set;
    logic [GRP_W-1:0] pad;

    always_comb begin
        true_rst    = old_grp & ~new_grp;
        true_set    = ~old_grp & new_grp;
        pad         = pad_mask(true_rst);
        ops.rst_ops = true_rst | pad;
        ops.set_ops = true_set | pad;
    end
endmodule

// File: rtl/prv_vec_builder.sv
module prv_vec_builder
    import prv_pkg::*;
#(
    parameter int LINE_W = 64
) (
    input  logic [LINE_W-1:0] old_line,
    input  logic [LINE_W-1:0] new_line,
    output logic [LINE_W-1:0] rst_line,
    output logic [LINE_W-1:0] set_line
);
    localparam int NGRP = LINE_W / GRP_W;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        grp_ops_t ops;
        prv_group_part u_part (
            .old_grp (old_line[g*GRP_W +: GRP_W]),
            .new_grp (new_line[g*GRP_W +: GRP_W]),
            .ops     (ops)
        );
        assign rst_line[g*GRP_W +: GRP_W] = ops.rst_ops;
        assign set_line[g*GRP_W +: GRP_W] = ops.set_ops;
    end
endmodule

// File: rtl/prv_phase_seq.sv
module prv_phase_seq
    import prv_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] rst_cycles,
    input  logic [CNT_W-1:0] set_cycles,
    output phase_e           phase_q,
    output logic             accept,
    output logic             done_q
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] set_len_q;

    function automatic logic [CNT_W-1:0] last_idx(input logic [CNT_W-1:0] len);
        return (len == '0) ? '0 : len - 1'b1;
    endfunction

    assign accept = (phase_q == PH_IDLE) && start;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            cnt_q     <= '0;
            set_len_q <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        phase_q   <= PH_RESET;
                        cnt_q     <= last_idx(rst_cycles);
                        set_len_q <= last_idx(set_cycles);
                    end
                end
                PH_RESET: begin
                    if (cnt_q == '0) begin
                        phase_q <= PH_SET;
                        cnt_q   <= set_len_q;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_SET: begin
                    if (cnt_q == '0) begin
                        phase_q <= PH_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/prv_partition_reset.sv
module prv_partition_reset
    import prv_pkg::*;
#(
    parameter int LINE_W = 64,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [LINE_W-1:0] old_data,
    input  logic [LINE_W-1:0] new_data,
    input  logic [CNT_W-1:0]  rst_cycles,
    input  logic [CNT_W-1:0]  set_cycles,
    output logic [LINE_W-1:0] reset_vec,
    output logic [LINE_W-1:0] set_vec,
    output logic [1:0]        phase,
    output logic              done
);
    initial begin
        if (LINE_W % GRP_W != 0 || LINE_W < GRP_W)
            $error("LINE_W must be a positive multiple of 8");
    end

    logic [LINE_W-1:0] rst_next;
    logic [LINE_W-1:0] set_next;
    logic [LINE_W-1:0] rst_q;
    logic [LINE_W-1:0] set_q;
    phase_e            phase_q;
    logic              accept;
    logic              done_q;

    prv_vec_builder #(.LINE_W(LINE_W)) u_build (
        .old_line (old_data),
        .new_line (new_data),
        .rst_line (rst_next),
        .set_line (set_next)
    );

    prv_phase_seq #(.CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .rst_cycles (rst_cycles),
        .set_cycles (set_cycles),
        .phase_q    (phase_q),
        .accept     (accept),
        .done_q     (done_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_q <= '0;
            set_q <= '0;
        end else if (accept) begin
            rst_q <= rst_next;
            set_q <= set_next;
        end
    end

    assign reset_vec = (phase_q == PH_RESET) ? rst_q : '0;
    assign set_vec   = (phase_q == PH_SET)   ? set_q : '0;
    assign phase     = phase_q;
    assign done      = done_q;
endmodule

// File: rtl/prv_checker.sv
module prv_checker #(
    parameter int LINE_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic [LINE_W-1:0] reset_vec,
    input logic [LINE_W-1:0] set_vec,
    input logic [1:0]        phase,
    input logic              done
);
    AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        phase != 2'd3); // R6

    AST_SET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd2 && $past(phase) != 2'd2) |-> $past(phase) == 2'd1); // R7

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8

    AST_DONE_ENDS_SET: assert property (@(posedge clk) disable iff (rst)
        done |-> (phase == 2'd0 && $past(phase) == 2'd2)); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        phase == 2'd0 |-> (reset_vec == '0 && set_vec == '0)); // R8

    AST_RESET_HELD: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd1 && $past(phase) == 2'd1) |-> $stable(reset_vec)); // R10

    AST_SET_HELD: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd2 && $past(phase) == 2'd2) |-> $stable(set_vec)); // R10
endmodule

bind prv_partition_reset prv_checker #(.LINE_W(LINE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reset_vec (reset_vec),
    .set_vec   (set_vec),
    .phase     (phase),
    .done      (done)
);

// File: tb/prv_partition_reset_bench.sv
`timescale 1ns/1ps
module prv_partition_reset_bench;
    localparam int LW = 64;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [LW-1:0] old_data = '0;
    logic [LW-1:0] new_data = '0;
    logic [CW-1:0] rst_cycles = '0;
    logic [CW-1:0] set_cycles = '0;
    logic [LW-1:0] reset_vec;
    logic [LW-1:0] set_vec;
    logic [1:0]    phase;
    logic          done;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    prv_partition_reset #(.LINE_W(LW), .CNT_W(CW)) u_prv_partition_reset (
        .clk(clk), .rst(rst), .start(start), .old_data(old_data),
        .new_data(new_data), .rst_cycles(rst_cycles), .set_cycles(set_cycles),
        .reset_vec(reset_vec), .set_vec(set_vec), .phase(phase), .done(done)
    );

    task automatic check(input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Padding computed from the highest RESET index of each slice.
    function automatic logic [LW-1:0] ref_pad(input logic [LW-1:0] o, input logic [LW-1:0] n);
        logic [LW-1:0] r;
        logic [LW-1:0] pad;
        r   = o & ~n;
        pad = '0;
        for (int g = 0; g < LW/8; g++) begin
            int hi;
            hi = -1;
            for (int b = 0; b < 8; b++)
                if (r[g*8+b]) hi = b;
            if (hi >= 3) begin
                for (int p = 0; p < hi/2; p++)
                    if (!r[g*8+2*p] && !r[g*8+2*p+1]) pad[g*8+2*p+1] = 1'b1;
            end
        end
        return pad;
    endfunction

    // Runs one write; checks each cycle of both phases and the done pulse.
    task automatic run_op(input string req, input logic [LW-1:0] o, input logic [LW-1:0] n,
                          input int rc, input int sc, input bit disturb);
        logic [LW-1:0] er;
        logic [LW-1:0] es;
        int nr;
        int ns;
        er = (o & ~n) | ref_pad(o, n);
        es = (~o & n) | ref_pad(o, n);
        nr = (rc == 0) ? 1 : rc;
        ns = (sc == 0) ? 1 : sc;
        @(negedge clk);
        old_data = o; new_data = n;
        rst_cycles = CW'(rc); set_cycles = CW'(sc);
        start = 1'b1;
        @(negedge clk);
        start = disturb;
        if (disturb) begin
            old_data = ~o; new_data = o;
            rst_cycles = 8'd1; set_cycles = 8'd1;
        end
        for (int i = 0; i < nr; i++) begin
            check({req, " R6 phase"}, LW'(phase), LW'(1));
            check({req, " R6 reset_vec"}, reset_vec, er);
            check({req, " R6 set_vec quiet"}, set_vec, '0);
            @(negedge clk);
        end
        for (int i = 0; i < ns; i++) begin
            check({req, " R7 phase"}, LW'(phase), LW'(2));
            check({req, " R7 set_vec"}, set_vec, es);
            check({req, " R7 reset_vec quiet"}, reset_vec, '0);
            @(negedge clk);
        end
        start = 1'b0;
        check({req, " R8 done"}, LW'(done), LW'(1));
        check({req, " R8 idle"}, LW'(phase), LW'(0));
        check({req, " R8 vecs zero"}, reset_vec | set_vec, '0);
        @(negedge clk);
        check({req, " R8 done drops"}, LW'(done), LW'(0));
        check({req, " R9 stays idle"}, LW'(phase), LW'(0));
    endtask

    task automatic t_reset_state;
        check("R11 phase", LW'(phase), LW'(0));
        check("R11 done", LW'(done), LW'(0));
        check("R11 vecs", reset_vec | set_vec, '0);
    endtask

    task automatic t_example;
        // R3: only local bit 7 resets -> RESET 0xAA, SET 0x2A (R4)
        check("R3 ref example", ref_pad(64'h80, 64'h0) | 64'h80, 64'hAA);
        run_op("R3", 64'h0000_0000_0000_0080, 64'h0, 3, 2, 1'b0);
    endtask

    task automatic t_low_only;
        // R2: resets in bits 0..2 only -> no padding
        run_op("R2", 64'h0000_0000_0000_0007, 64'h0, 2, 2, 1'b0);
    endtask

    task automatic t_collision;
        // R4: RESET bit4, SET bit1 -> RESET 0x1A, SET 0x0A
        check("R4 ref collision", ((64'h10 & ~64'h02) | ref_pad(64'h10, 64'h02)), 64'h1A);
        run_op("R4", 64'h10, 64'h02, 1, 1, 1'b0);
    endtask

    task automatic t_unchanged;
        run_op("R1", 64'hDEAD_BEEF_0123_4567, 64'hDEAD_BEEF_0123_4567, 2, 3, 1'b0);
        run_op("R1", 64'hF0F0_0000_FFFF_0000, 64'h0F0F_FFFF_FFFF_0000, 2, 2, 1'b0);
    endtask

    task automatic t_groups;
        run_op("R5", 64'h8040_2010_0804_0201, 64'h0102_0408_1020_4080, 4, 3, 1'b0);
        run_op("R5", 64'hFF00_C3A5_5A3C_9966, 64'h00FF_3C5A_A5C3_6699, 2, 5, 1'b0);
    endtask

    task automatic t_zero_len;
        run_op("R6", 64'h0000_0000_4000_0000, 64'h0, 0, 0, 1'b0);
    endtask

    task automatic t_busy;
        // R9 and R10: start held and inputs changed during run
        run_op("R10", 64'h0000_00C0_0000_0000, 64'h0000_0001_0000_0000, 3, 3, 1'b1);
        repeat (3) @(negedge clk);
        check("R9 no restart", LW'(phase), LW'(0));
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_example();
        t_low_only();
        t_collision();
        t_unchanged();
        t_groups();
        t_zero_len();
        t_busy();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule